// File: doc/BRIEF.md
# Down-Counting Event Timer Channel

This block is a single timer channel that counts down on a once-per-microsecond tick enable supplied by a prescaler elsewhere on the chip. Software programs a control word that carries a run bit, a repeat bit and a 29-bit reload value. A programmed value n makes the channel expire on the (n+1)-th tick, so a request for c ticks is written as c-1, and a request for one tick is written as 0. On expiry the channel raises a level interrupt that stays high until software acknowledges it through a second register.

In one-shot use the channel stops itself after the first expiry. In repeating use it reloads on the expiring tick and continues, giving an interrupt every n+1 ticks; a periodic system tick is made by writing the tick rate divided by the desired frequency, minus one, with both the run and repeat bits set. Writing an all-zero control word stops the channel. The status register reports the pending flag together with the live count.

Top module: `evt_timer`

## Requirements
- R1: After synchronous reset the channel is stopped, the interrupt output is low, and reads of both registers return 0.
- R2: Bit 2 of the byte address selects the register (0: control, 1: status). A control write stores bit 31 as the run bit, bit 30 as the repeat bit and bits 28:0 as the reload value, and loads bits 28:0 into the counter in the same cycle; a control read returns these three fields in the same positions with all other bits 0 (bit 29 is not stored).
- R3: While running, each cycle with the tick enable high decrements the counter; a loaded value n sets the interrupt on the (n+1)-th tick. Cycles without a tick leave the counter unchanged.
- R4: In one-shot mode (repeat bit 0) the run bit clears itself on expiry, the counter stays at 0 and no further expiry occurs until the control register is written again.
- R5: In repeat mode the counter reloads from the reload value on the expiring tick, so expiries occur every n+1 ticks.
- R6: Writing 0 to the control register stops the channel: later ticks neither change the counter nor raise the interrupt.
- R7: A status write with bit 30 set clears the pending interrupt; a status write with bit 30 clear leaves it unchanged.
- R8: When an expiry and a clearing status write fall in the same cycle, the interrupt stays set.
- R9: A status read returns the pending flag in bit 30 and the live count in bits 28:0, other bits 0. Read data is registered and appears one cycle after the read address, reflecting the state before that edge.
- R10: While stopped, the tick enable has no effect on the counter or the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle microsecond tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Byte address of the write (bit 2 decoded) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Byte address of the read (bit 2 decoded) |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, high while an expiry is pending |

## Verification
The hardest situation to reach from the ports is an acknowledge that lands in exactly the cycle the counter expires, since it needs a tick, a zero count and a status write together. The stimulus reaches it directly by loading a repeating channel with value 0, so every tick expires, and issuing the acknowledge on a tick cycle; the random phase keeps reload values small and writes frequent so that such coincidences, and control writes landing on expiring ticks, also recur by chance against the bench's reference model.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int RUN_BIT    = 31;
  localparam int REPEAT_BIT = 30;
  localparam int ACK_BIT    = 30;
  localparam int PEND_BIT   = 30;
  localparam int SEL_BIT    = 2;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/evt_timer_ctrl.sv
module evt_timer_ctrl #(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr,
  input  logic             run_in,
  input  logic             repeat_in,
  input  logic [CNT_W-1:0] value_in,
  input  logic             oneshot_done,
  output logic             run,
  output logic             repeat_mode,
  output logic [CNT_W-1:0] reload
);
  always_ff @(posedge clk) begin
    if (rst) begin
      run         <= 1'b0;
      repeat_mode <= 1'b0;
      reload      <= '0;
    end else if (ctrl_wr) begin
      run         <= run_in;
      repeat_mode <= repeat_in;
      reload      <= value_in;
    end else if (oneshot_done) begin
      run <= 1'b0;
    end
  end

  // R4: a one-shot expiry stops the channel
  a_r4_self_stop: assert property (@(posedge clk) disable iff (rst)
    oneshot_done && !ctrl_wr |=> !run);
  // R2: control write fields are captured
  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (run == $past(run_in)) && (reload == $past(value_in)));
endmodule

// File: rtl/evt_timer_count.sv
module evt_timer_count #(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             ctrl_wr,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  input  logic             repeat_mode,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic at_zero;
  logic step;

  assign at_zero = (count == '0);
  assign step    = tick_en && run && !ctrl_wr;
  assign expire  = step && at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (ctrl_wr) begin
      count <= load_val;
    end else if (step) begin
      if (!at_zero) begin
        count <= count - 1'b1;
      end else if (repeat_mode) begin
        count <= reload;
      end
    end
  end

  // R3: a tick on a nonzero count decrements by one
  a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
    tick_en && run && !ctrl_wr && (count != '0) |=> count == $past(count) - 1'b1);
  // R5: repeat expiry reloads
  a_r5_reload: assert property (@(posedge clk) disable iff (rst)
    expire && repeat_mode |=> count == $past(reload));
  // R10: a stopped channel holds its count
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !run && !ctrl_wr |=> $stable(count));
  // R2: a control write loads the counter at once
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> count == $past(load_val));
endmodule

// File: rtl/evt_timer_flag.sv
module evt_timer_flag (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic ack,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
    end else if (expire) begin
      pend <= 1'b1;
    end else if (ack) begin
      pend <= 1'b0;
    end
  end

  // R8: a new expiry wins over a same-cycle acknowledge
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    expire |=> pend);
  // R7: an acknowledge alone clears
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    ack && !expire |=> !pend);
  // R7: without expiry or acknowledge the flag holds
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !ack && !expire |=> $stable(pend));
endmodule

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 29
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  import evt_timer_pkg::*;

  reg_sel_e         wr_sel;
  reg_sel_e         rd_sel;
  logic             ctrl_wr;
  logic             ack;
  logic             run;
  logic             repeat_mode;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] count;
  logic             expire;
  logic             pend;
  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] stat_word;
  logic             unused_bits;

  assign wr_sel  = reg_sel_e'(wr_addr[SEL_BIT]);
  assign rd_sel  = reg_sel_e'(rd_addr[SEL_BIT]);
  assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
  assign ack     = wr_en && (wr_sel == SEL_STAT) && wr_data[ACK_BIT];
  assign unused_bits = ^{wr_addr, rd_addr, wr_data};

  evt_timer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .ctrl_wr      (ctrl_wr),
    .run_in       (wr_data[RUN_BIT]),
    .repeat_in    (wr_data[REPEAT_BIT]),
    .value_in     (wr_data[CNT_W-1:0]),
    .oneshot_done (expire && !repeat_mode),
    .run          (run),
    .repeat_mode  (repeat_mode),
    .reload       (reload)
  );

  evt_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk         (clk),
    .rst         (rst),
    .tick_en     (tick_en),
    .ctrl_wr     (ctrl_wr),
    .load_val    (wr_data[CNT_W-1:0]),
    .run         (run),
    .repeat_mode (repeat_mode),
    .reload      (reload),
    .count       (count),
    .expire      (expire)
  );

  evt_timer_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .expire (expire),
    .ack    (ack),
    .pend   (pend)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CNT_W-1:0]  = reload;
    ctrl_word[RUN_BIT]    = run;
    ctrl_word[REPEAT_BIT] = repeat_mode;
    stat_word = '0;
    stat_word[CNT_W-1:0]  = count;
    stat_word[PEND_BIT]   = pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= (rd_sel == SEL_STAT) ? stat_word : ctrl_word;
    end
  end

  assign irq = pend;

  // R6: a stopped channel never raises a new interrupt
  a_r6_quiet_stopped: assert property (@(posedge clk) disable iff (rst)
    !run && !pend |=> !pend);
  // R9: status read returns pending flag in bit 30
  a_r9_stat_flag: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == SEL_STAT) |=> rd_data[PEND_BIT] == $past(pend));
endmodule

// File: tb/evt_timer_tb.sv
module evt_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic        m_run, m_rep, m_pend;
  logic [28:0] m_rel, m_cnt;
  logic [31:0] exp_rd;

  always #4 clk = ~clk;

  evt_timer u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [31:0] model_read(input logic [2:0] ra);
    if (ra[2]) return {1'b0, m_pend, 1'b0, m_cnt};
    return {m_run, m_rep, 1'b0, m_rel};
  endfunction

  task automatic model_update(input logic t, input logic we,
                              input logic [2:0] wa, input logic [31:0] wd);
    logic ex;
    ex = 1'b0;
    if (we && !wa[2]) begin
      m_run = wd[31]; m_rep = wd[30]; m_rel = wd[28:0]; m_cnt = wd[28:0];
    end else if (t && m_run) begin
      if (m_cnt == 0) begin
        ex = 1'b1;
        if (m_rep) m_cnt = m_rel; else m_run = 1'b0;
      end else begin
        m_cnt = m_cnt - 1;
      end
    end
    if (ex) m_pend = 1'b1;
    else if (we && wa[2] && wd[30]) m_pend = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, expv);
    end
  endtask

  task automatic step(input logic t, input logic we, input logic [2:0] wa,
                      input logic [31:0] wd, input logic [2:0] ra, input string tag);
    tick_en = t; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    @(posedge clk);
    exp_rd = model_read(ra);
    model_update(t, we, wa, wd);
    #2;
    chk({tag, " irq"}, {31'd0, irq}, {31'd0, m_pend});
    chk({tag, " rd"}, rd_data, exp_rd);
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_run = 0; m_rep = 0; m_pend = 0; m_rel = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    step(0, 0, 3'd0, 0, 3'd0, "R1");
    chk("R1 ctrl", rd_data, 32'h0);
    step(0, 0, 3'd0, 0, 3'd4, "R1");
    chk("R1 stat", rd_data, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R2: load and readback
    step(0, 1, 3'd0, 32'h8000_0005, 3'd0, "R2");
    step(0, 0, 3'd0, 0, 3'd0, "R2");
    chk("R2 ctrl", rd_data, 32'h8000_0005);
    step(0, 0, 3'd0, 0, 3'd4, "R9");
    chk("R9 stat", rd_data, 32'h0000_0005);

    // R3: n+1 ticks with idle gaps
    for (int i = 0; i < 5; i++) begin
      step(1, 0, 3'd0, 0, 3'd4, "R3");
      step(0, 0, 3'd0, 0, 3'd4, "R3");
    end
    chk("R3 no early irq", {31'd0, irq}, 32'd0);
    chk("R3 count", rd_data, 32'h0);
    step(1, 0, 3'd0, 0, 3'd4, "R3");
    chk("R3 irq on n+1", {31'd0, irq}, 32'd1);

    // R4: one-shot stops
    step(0, 0, 3'd0, 0, 3'd0, "R4");
    chk("R4 run cleared", rd_data, 32'h0000_0005);
    for (int i = 0; i < 3; i++) step(1, 0, 3'd0, 0, 3'd4, "R4");
    step(0, 0, 3'd0, 0, 3'd4, "R4");
    chk("R4 stat", rd_data, 32'h4000_0000);

    // R7: acknowledge semantics
    step(0, 1, 3'd4, 32'hBFFF_FFFF, 3'd4, "R7");
    chk("R7 no-ack keeps", {31'd0, irq}, 32'd1);
    step(0, 1, 3'd4, 32'h4000_0000, 3'd4, "R7");
    chk("R7 ack clears", {31'd0, irq}, 32'd0);
    for (int i = 0; i < 3; i++) step(1, 0, 3'd0, 0, 3'd4, "R4");
    chk("R4 no re-expiry", {31'd0, irq}, 32'd0);

    // R5: repeating, n=2
    step(0, 1, 3'd0, 32'hC000_0002, 3'd4, "R5");
    step(1, 0, 3'd0, 0, 3'd4, "R5");
    step(1, 0, 3'd0, 0, 3'd4, "R5");
    chk("R5 before", {31'd0, irq}, 32'd0);
    step(1, 0, 3'd0, 0, 3'd4, "R5");
    chk("R5 first", {31'd0, irq}, 32'd1);
    step(0, 1, 3'd4, 32'h4000_0000, 3'd4, "R5");
    chk("R5 reloaded", rd_data, 32'h4000_0002);
    step(1, 0, 3'd0, 0, 3'd4, "R5");
    step(1, 0, 3'd0, 0, 3'd4, "R5");
    chk("R5 gap", {31'd0, irq}, 32'd0);
    step(1, 0, 3'd0, 0, 3'd4, "R5");
    chk("R5 second", {31'd0, irq}, 32'd1);

    // R8: acknowledge on an expiring tick
    step(0, 1, 3'd0, 32'hC000_0000, 3'd4, "R8");
    step(1, 1, 3'd4, 32'h4000_0000, 3'd4, "R8");
    chk("R8 set wins", {31'd0, irq}, 32'd1);
    step(0, 1, 3'd4, 32'h4000_0000, 3'd4, "R8");
    chk("R8 later ack", {31'd0, irq}, 32'd0);

    // R6 / R10: stop by writing 0
    step(0, 1, 3'd0, 32'h8000_0003, 3'd4, "R6");
    step(1, 0, 3'd0, 0, 3'd4, "R6");
    step(0, 1, 3'd0, 32'h0, 3'd4, "R6");
    for (int i = 0; i < 6; i++) step(1, 0, 3'd0, 0, 3'd4, "R10");
    step(0, 0, 3'd0, 0, 3'd4, "R6");
    chk("R6 stopped stat", rd_data, 32'h0);
    chk("R6 no irq", {31'd0, irq}, 32'd0);

    // R2: maximum value and unstored bit 29
    step(0, 1, 3'd0, 32'hFFFF_FFFF, 3'd0, "R2");
    step(1, 0, 3'd0, 0, 3'd0, "R2");
    chk("R2 bit29 dropped", rd_data, 32'hDFFF_FFFF);
    step(0, 0, 3'd0, 0, 3'd4, "R9");
    chk("R9 max-1", rd_data, 32'h1FFF_FFFE);
    step(0, 1, 3'd0, 32'h0, 3'd4, "R6");

    // random phase against the reference model (R3, R5, R7, R8)
    for (int i = 0; i < 4000; i++) begin
      logic        t, we;
      logic [2:0]  wa;
      logic [31:0] wd;
      t  = ($urandom_range(0, 1) == 1);
      we = ($urandom_range(0, 9) == 0);
      wa = $urandom_range(0, 1) ? 3'd4 : 3'd0;
      wd = $urandom;
      if (!wa[2]) wd[28:0] = 29'($urandom_range(0, 6));
      step(t, we, wa, wd, 3'($urandom_range(0, 7)), "R5 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule